// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Symbol Transmitter

This block drives one wire of a variable-pulse-width serial bus. Each bit is a pulse whose width carries the value, and the line changes level at the start of every bit. The width rule depends on the line's state. A short passive pulse is a 0 and a long passive pulse is a 1. When the line is active the rule is reversed: a long pulse is a 0 and a short pulse is a 1. All widths are counted in pulses of a slow timing enable (`tick`) that an external prescaler provides. Cycles without a tick do not advance any duration.

A frame begins on request with a long active start pulse. Bytes are then taken one at a time over a ready/valid interface, and the next byte is offered only at a byte boundary. When no byte is waiting at a boundary, the line falls passive as end of data. Once the passive stretch has lasted long enough to count as end of frame, the block pulses `frame_done`. A new start is held off until the passive line has lasted the inter-frame gap. A break request overrides everything and holds the line active for at least a minimum time.

Top module: `vpw_tx`

## Requirements
- R1: After synchronous reset `line_active` is 0 (passive), `frame_done` and `in_ready` are 0, and the inter-frame gap counts as already met, so a start request is honoured on the first clock edge after reset.
- R2: A start request in idle raises `line_active` to 1 and holds it for exactly 200 ticks.
- R3: A bit sent with the line passive (0) lasts 64 ticks for value 0 and 128 ticks for value 1.
- R4: A bit sent with the line active (1) lasts 128 ticks for value 0 and 64 ticks for value 1.
- R5: Bytes go out most significant bit first. The line toggles at the start of every bit, so the first bit after the start pulse is passive and every byte ends with the line active.
- R6: `in_ready` is high only in a cycle with `tick` high that ends the start pulse or the eighth bit of a byte. A byte moves only when `in_valid` and `in_ready` are both high at a clock edge.
- R7: If no byte is valid at a byte boundary, the line goes passive. After 280 ticks of passive line, counting the tick of that transition edge as part of the last bit, `frame_done` pulses high for exactly one cycle.
- R8: A start request is not honoured until the line has been passive for 300 ticks since the end-of-data transition or since the end of a break.
- R9: A break request in any state drives the line active. The line stays active for at least 240 ticks and for as long as the request is held, then returns passive to idle without a `frame_done` pulse.
- R10: Durations advance only on cycles with `tick` high. While a bit is in progress and `tick` stays low, the line does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timing enable; one pulse is one duration unit |
| sof_req | input | 1 | Request to start a frame (level, held until the line goes active) |
| brk_req | input | 1 | Break request (level) |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Byte to send, MSB first |
| in_ready | output | 1 | The byte on in_data is taken at this edge if in_valid is high |
| line_active | output | 1 | Bus line level: 1 active, 0 passive |
| frame_done | output | 1 | One-cycle pulse when end of frame is reached |

## Verification
The assertions check on every cycle the invariants that hold locally. They confirm that the line is passive in idle and end of data, and active during the start pulse. They also confirm that `in_ready` appears only with a tick, that `frame_done` lasts one cycle and follows end of data, and that a start never comes before the gap is met. A break never ends short, the counter and line hold still without ticks, and the first bit after a load is the byte's MSB. Exact pulse widths for each value and polarity can only be shown by the bench's scenarios. The bench measures every line segment in ticks and compares it with widths computed from the bytes sent. It also covers the 280-tick end-of-frame point and the gap after breaks, under random and continuous tick patterns.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_BIT,
    ST_EOD,
    ST_BRK
  } vpw_state_e;

  // Width of a data pulse: long when line level and bit value differ.
  function automatic int unsigned pulse_ticks(input logic active, input logic value,
                                              input int unsigned t_short,
                                              input int unsigned t_long);
    return (active ^ value) ? t_long : t_short;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vpw_tick_timer.sv
module vpw_tick_timer #(
  parameter int CNT_W   = 9,
  parameter int SAT     = 300,
  parameter int RST_VAL = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] RST_C = CNT_W'(RST_VAL);

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= RST_C;
    else if (clr)                  cnt <= '0;
    else if (tick && cnt < SAT_C)  cnt <= cnt + 1'b1;
  end

  // R10: without a tick the count does not move
  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/vpw_bit_shifter.sv
module vpw_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         cur_bit,
  output logic         last_bit
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(W - 1);

  logic [W-1:0]     sr;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= din;
      idx <= '0;
    end else if (shift) begin
      sr  <= sr << 1;
      idx <= idx + 1'b1;
    end
  end

  assign cur_bit  = sr[W-1];
  assign last_bit = (idx == LAST_IDX);

  // R5: the bit on the line after a load is the byte's MSB
  a_r5_msb_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_bit == $past(din[W-1])));

endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
  import vpw_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int T_SHORT = 64,
  parameter int T_LONG  = 128,
  parameter int T_SOF   = 200,
  parameter int T_EOF   = 280,
  parameter int T_BRK   = 240,
  parameter int T_IFS   = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sof_req,
  input  logic              brk_req,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line_active,
  output logic              frame_done
);
  localparam int T_TOP = int'(max2(max2(max2(T_SOF, T_EOF), max2(T_BRK, T_IFS)),
                                   max2(T_SHORT, T_LONG)));
  localparam int CNT_W = $clog2(T_TOP + 1);
  localparam logic [CNT_W-1:0] IFS_C = CNT_W'(T_IFS);
  localparam logic [CNT_W-1:0] BRK_C = CNT_W'(T_BRK);

  vpw_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur;
  logic             cur_bit, last_bit;

  // named internal events
  logic timed_state, seg_end, byte_edge, ev_start, ev_brk, brk_end;
  logic load, shift, clr;

  always_comb begin
    unique case (st)
      ST_SOF:  dur = CNT_W'(T_SOF);
      ST_BIT:  dur = CNT_W'(pulse_ticks(line_active, cur_bit, T_SHORT, T_LONG));
      ST_EOD:  dur = CNT_W'(T_EOF);
      default: dur = CNT_W'(T_TOP);
    endcase
  end

  assign timed_state = (st == ST_SOF) || (st == ST_BIT) || (st == ST_EOD);
  assign seg_end     = timed_state && tick && (cnt == dur - 1'b1);
  assign byte_edge   = seg_end && ((st == ST_SOF) || ((st == ST_BIT) && last_bit));
  assign ev_brk      = brk_req && (st != ST_BRK);
  assign ev_start    = (st == ST_IDLE) && sof_req && !brk_req && (cnt >= IFS_C);
  assign brk_end     = (st == ST_BRK) && !brk_req && (cnt >= BRK_C);

  assign in_ready = byte_edge && !brk_req;
  assign load     = in_ready && in_valid;
  assign shift    = seg_end && (st == ST_BIT) && !last_bit && !brk_req;
  assign clr      = ev_brk || ev_start || brk_end || (seg_end && (st != ST_EOD));

  vpw_tick_timer #(
    .CNT_W  (CNT_W),
    .SAT    (T_TOP),
    .RST_VAL(T_IFS)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .clr (clr),
    .cnt (cnt)
  );

  vpw_bit_shifter #(
    .W(DATA_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .shift   (shift),
    .din     (in_data),
    .cur_bit (cur_bit),
    .last_bit(last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      line_active <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (ev_brk) begin
        st          <= ST_BRK;
        line_active <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: if (ev_start) begin
            st          <= ST_SOF;
            line_active <= 1'b1;
          end
          ST_SOF, ST_BIT: if (seg_end) begin
            if (byte_edge && !in_valid) begin
              st          <= ST_EOD;
              line_active <= 1'b0;
            end else begin
              st          <= ST_BIT;
              line_active <= ~line_active;
            end
          end
          ST_EOD: if (seg_end) begin
            st         <= ST_IDLE;
            frame_done <= 1'b1;
          end
          ST_BRK: if (brk_end) begin
            st          <= ST_IDLE;
            line_active <= 1'b0;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: idle means a passive line
  a_r1_idle_passive: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !line_active);
  // R2: start pulse is active
  a_r2_sof_active: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOF) |-> line_active);
  // R6: a byte is offered only on a timing tick
  a_r6_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tick);
  // R7: end of data keeps the line passive
  a_r7_eod_passive: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EOD) |-> !line_active);
  // R7: frame_done follows end of data and lasts one cycle
  a_r7_done_src: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(st) == ST_EOD));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R8: a frame starts only once the gap has been met
  a_r8_gap_met: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_SOF) && ($past(st) == ST_IDLE)) |-> ($past(cnt) >= IFS_C));
  // R9: a break never ends short
  a_r9_brk_min: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && ($past(st) == ST_BRK)) |-> ($past(cnt) >= BRK_C));
  // R10: no line change inside a bit without a tick
  a_r10_line_hold: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_BIT) && !tick && !brk_req) |=> $stable(line_active));

endmodule

// File: tb/vpw_tx_tb.sv
module vpw_tx_tb;

  typedef struct {
    logic  lvl;
    int    len;
    int    kind;  // 0 exact, 1 minimum, 2 any
    string tag;
  } seg_t;

  logic clk = 1'b0;
  logic rst, tick, sof_req, brk_req, in_valid;
  logic [7:0] in_data;
  wire in_ready, line_active, frame_done;

  vpw_tx u_dut (
    .clk(clk), .rst(rst), .tick(tick), .sof_req(sof_req), .brk_req(brk_req),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .line_active(line_active), .frame_done(frame_done)
  );

  always #4 clk = ~clk;

  seg_t       expq[$];
  logic [7:0] byteq[$];
  int errors = 0, checks = 0, cyc = 0, seg_cnt = 0, done_seen = 0, frames_exp = 0;
  logic prev_line = 1'b0;
  bit hs_pend = 0, pause = 0, fast = 0, timeout = 0, mon_en = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int bit_len(input logic lvl, input logic b);
    if (!lvl) return b ? 128 : 64;
    return b ? 64 : 128;
  endfunction

  task automatic push_seg(input logic lvl, input int len, input int kind, input string tag);
    seg_t s;
    s.lvl = lvl; s.len = len; s.kind = kind; s.tag = tag;
    expq.push_back(s);
  endtask

  task automatic end_segment(input logic lvl, input int len);
    seg_t e;
    if (expq.size() == 0) begin
      chk(0, "R5", "unexpected segment", len, 0);
      return;
    end
    e = expq.pop_front();
    chk(lvl == e.lvl, e.tag, "segment level", int'(lvl), int'(e.lvl));
    if (e.kind == 0)      chk(len == e.len, e.tag, "segment ticks", len, e.len);
    else if (e.kind == 1) chk(len >= e.len, e.tag, "segment min ticks", len, e.len);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (mon_en) begin
      if (tick) seg_cnt++;
      if (frame_done) begin
        done_seen++;
        chk(seg_cnt == 280 && !line_active, "R7", "passive ticks at frame_done", seg_cnt, 280);
      end
      if (line_active !== prev_line) begin
        end_segment(prev_line, seg_cnt);
        seg_cnt   = 0;
        prev_line = line_active;
      end
      if (sof_req && line_active) sof_req = 1'b0;
    end
    if (hs_pend) void'(byteq.pop_front());
    tick     = pause ? 1'b0 : (fast ? 1'b1 : 1'($urandom_range(0, 1)));
    in_valid = (byteq.size() > 0);
    in_data  = (byteq.size() > 0) ? byteq[0] : 8'h00;
    #1;
    hs_pend = in_valid && in_ready;
    if (in_ready) chk(tick == 1'b1, "R6", "in_ready without tick", int'(tick), 1);
    if (cyc > 190000 && !timeout) begin
      timeout = 1;
      chk(0, "watchdog", "run did not finish", cyc, 190000);
    end
  endtask

  task automatic run_frame(input int n, input bit directed, input bit do_pause);
    logic [7:0] b;
    logic lvl;
    int waited;
    if (timeout) return;
    push_seg(1'b1, 200, 0, "R2");
    lvl = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (directed) b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'hA5;
      else          b = 8'($urandom);
      byteq.push_back(b);
      for (int k = 7; k >= 0; k--) begin
        lvl = ~lvl;
        push_seg(lvl, bit_len(lvl, b[k]), 0, lvl ? "R4" : "R3");
      end
    end
    push_seg(1'b0, 300, 1, "R8");
    frames_exp++;
    sof_req = 1'b1;
    waited = 0;
    while (!line_active && !timeout) begin
      step();
      waited++;
    end
    if (frames_exp == 1) chk(waited <= 2, "R1", "cycles to first start", waited, 1);
    if (do_pause && n > 0) begin
      logic held;
      for (int i = 0; i < 450; i++) step();
      pause = 1;
      step();
      held = line_active;
      for (int i = 0; i < 150; i++) step();
      chk(line_active == held, "R10", "line moved without tick", int'(line_active), int'(held));
      pause = 0;
    end
    while (done_seen < frames_exp && !timeout) step();
  endtask

  task automatic run_break(input int hold);
    if (timeout) return;
    while ((line_active || seg_cnt < 310) && !timeout) step();
    push_seg(1'b1, 240, 1, "R9");
    push_seg(1'b0, 300, 1, "R8");
    brk_req = 1'b1;
    for (int i = 0; i < hold; i++) step();
    brk_req = 1'b0;
    while (line_active && !timeout) step();
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst = 1'b1; tick = 1'b0; sof_req = 1'b0; brk_req = 1'b0;
    in_valid = 1'b0; in_data = 8'h00;
    for (int i = 0; i < 4; i++) step();
    rst = 1'b0;
    @(negedge clk);
    chk(line_active == 1'b0, "R1", "line after reset", int'(line_active), 0);
    chk(frame_done == 1'b0, "R1", "frame_done after reset", int'(frame_done), 0);
    chk(in_ready == 1'b0, "R1", "in_ready after reset", int'(in_ready), 0);
    prev_line = line_active;
    seg_cnt   = 0;
    mon_en    = 1;
    push_seg(1'b0, 0, 2, "R1");

    run_frame(3, 1, 0);             // R3 R4 R5: 00, FF, A5
    run_frame(0, 0, 0);             // R7: no byte at first boundary
    run_frame(2, 0, 1);             // R10: tick pause mid-frame
    fast = 1;
    run_frame(2, 0, 0);             // continuous ticks
    run_break(3);                   // R9: short request
    run_frame(1, 0, 0);
    run_break(700);                 // R9: held request
    fast = 0;
    run_frame(1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      fast = (i % 3 == 2);
      run_frame($urandom_range(0, 3), 0, 0);
    end
    for (int i = 0; i < 600; i++) step();

    chk(done_seen == frames_exp, "R9", "frame_done count", done_seen, frames_exp);
    chk(expq.size() == 1, "R5", "pending segments", expq.size(), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule